// File: doc/BRIEF.md
# Fall-Through Marker Chain FIFO

This block is a first-in first-out store built as a chain of stages. Each stage holds one word and a marker bit that says whether the word is valid. A word enters at the head stage. On each clock it moves forward into the stage in front of it whenever that stage is empty, so it drifts down the chain until it reaches the tail. The tail stage drives the output bus. The default chain is 16 stages of 4-bit words.

The writer raises `shift_in` to offer a word and sees `in_ready` as its flag. The reader drops `shift_out` to take the presented word and sees `out_ready` as its flag. Both strobes are sampled on the system clock, and only their edges act. A master clear wipes the markers but leaves the stored bits alone. A float control parks the output bus and has no effect on the unload path.

Top module: `ripple_fifo`

## Requirements
- R1: Words leave in exactly the order they were accepted, and up to DEPTH (default 16) words of WORD_W (4) bits are held at once.
- R2: A word accepted at a clock edge, with every stage ahead of it empty, reaches the tail DEPTH-1 edges later. At that point `out_ready` is 1 and `q_data` shows the word.
- R3: A word on `din` is accepted at an edge where `shift_in` is 1, was 0 at the previous edge, and `in_ready` is 1. After acceptance `in_ready` is 0 for one clock, provided the second stage is empty. Holding `shift_in` high takes only one word.
- R4: With DEPTH words stored, `in_ready` is 0 and rising `shift_in` edges store nothing. This includes an edge that coincides with an unload.
- R5: An edge where `shift_out` is 0, was 1 at the previous edge, and `out_ready` is 1 removes the tail word. `out_ready` is then 0 for one clock. If a word was waiting directly behind the tail, `out_ready` returns to 1 with that word on `q_data`. Otherwise the tail word is held.
- R6: While no word is at the tail, `out_ready` stays 0 and falling `shift_out` edges remove nothing.
- R7: `mclr` high at an edge clears every marker, so `in_ready` is 1 and `out_ready` is 0. The word bits are kept, and `q_data` still shows the former tail contents.
- R8: If `shift_in` is 1 while `mclr` is high, the word on `din` is loaded at the first edge after `mclr` falls.
- R9: `float_out` high sets `q_drive` to 0 and `q_data` to 0 within the same cycle. Unloading works the same whatever the value of `float_out`.
- R10: A load at the head and an unload at the tail at the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mclr | input | 1 | Synchronous active-high master clear of the markers |
| shift_in | input | 1 | Load strobe; acts on its rising edge |
| din | input | 4 | Word to load |
| in_ready | output | 1 | Head stage is empty |
| shift_out | input | 1 | Unload strobe; acts on its falling edge |
| out_ready | output | 1 | Tail stage holds a valid word |
| float_out | input | 1 | High parks the output bus |
| q_drive | output | 1 | 1 when the output bus is driven |
| q_data | output | 4 | Tail word, or 0 while parked |

## Verification
A load at the head and an unload at the tail can fall on the same clock edge. The bench provokes this by raising `shift_in` and lowering `shift_out` at the same negative edge, once on a FIFO that holds a single word and once on a full FIFO.

In the first case, both flags must drop together, and the new word must then appear at the tail after the full fall-through delay. In the full case, the unload must go ahead while the load is refused. This is confirmed by draining all sixteen words in order and then finding the FIFO empty.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    localparam int WORD_W    = 4;
    localparam int DEPTH_DEF = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  mark;
        word_t data;
    } stage_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    function automatic logic edge_hit(edge_kind_e kind, logic now_v, logic prev_v);
        return (kind == EDGE_RISE) ? (now_v & ~prev_v) : (~now_v & prev_v);
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
    import fifo_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_RISE
) (
    input  logic clk,
    input  logic clr,
    input  logic strobe,
    output logic hit
);

    logic prev_q;

    // Cleared under master clear so a strobe held high across clear reads as fresh
    always_ff @(posedge clk) begin
        if (clr) prev_q <= 1'b0;
        else     prev_q <= strobe;
    end

    assign hit = ~clr & edge_hit(KIND, strobe, prev_q);

endmodule

// File: rtl/fifo_cell.sv
module fifo_cell
    import fifo_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   up_mark,
    input  word_t  up_word,
    input  logic   down_busy,
    input  logic   drop,
    output stage_t st
);

    logic  mark_q;
    word_t data_q;
    logic  accept;
    logic  leave;

    assign accept = up_mark & ~mark_q;
    assign leave  = mark_q & ~down_busy;

    always_ff @(posedge clk) begin
        if (clr) mark_q <= 1'b0;
        else     mark_q <= (mark_q & ~leave & ~drop) | accept;
    end

    // Word bits carry no reset: a clear only invalidates them
    always_ff @(posedge clk) begin
        if (!clr && accept) data_q <= up_word;
    end

    assign st = '{mark: mark_q, data: data_q};

endmodule

// File: rtl/out_port.sv
module out_port
    import fifo_pkg::*;
(
    input  logic  float_out,
    input  word_t word,
    output logic  drive,
    output word_t q
);

    assign drive = ~float_out;
    assign q     = float_out ? '0 : word;

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
    import fifo_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF
) (
    input  logic              clk,
    input  logic              mclr,
    input  logic              shift_in,
    input  logic [WORD_W-1:0] din,
    output logic              in_ready,
    input  logic              shift_out,
    output logic              out_ready,
    input  logic              float_out,
    output logic              q_drive,
    output logic [WORD_W-1:0] q_data
);

    localparam int W    = WORD_W;
    localparam int LAST = DEPTH - 1;

    stage_t           cells [DEPTH];
    logic [DEPTH-1:0] marks;
    logic             si_rise;
    logic             so_fall;
    logic             push;
    logic             pop;
    word_t            out_word;

    strobe_edge #(.KIND(EDGE_RISE)) u_si_edge (
        .clk(clk), .clr(mclr), .strobe(shift_in), .hit(si_rise)
    );

    strobe_edge #(.KIND(EDGE_FALL)) u_so_edge (
        .clk(clk), .clr(mclr), .strobe(shift_out), .hit(so_fall)
    );

    assign in_ready  = ~marks[0];
    assign out_ready = marks[LAST];
    assign push      = si_rise & in_ready;
    assign pop       = so_fall & out_ready;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic  up_m;
        word_t up_w;
        logic  busy;
        logic  drp;

        if (i == 0) begin : g_head
            assign up_m = push;
            assign up_w = din;
        end else begin : g_body
            assign up_m = cells[i-1].mark;
            assign up_w = cells[i-1].data;
        end

        if (i == LAST) begin : g_tail
            assign busy = 1'b1;
            assign drp  = pop;
        end else begin : g_mid
            assign busy = cells[i+1].mark;
            assign drp  = 1'b0;
        end

        fifo_cell u_cell (
            .clk       (clk),
            .clr       (mclr),
            .up_mark   (up_m),
            .up_word   (up_w),
            .down_busy (busy),
            .drop      (drp),
            .st        (cells[i])
        );

        assign marks[i] = cells[i].mark;
    end

    assign out_word = cells[LAST].data;

    out_port u_out (
        .float_out (float_out),
        .word      (out_word),
        .drive     (q_drive),
        .q         (q_data)
    );

endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int W     = 4
) (
    input logic             clk,
    input logic             mclr,
    input logic             si_rise,
    input logic             so_fall,
    input logic             push,
    input logic             pop,
    input logic             in_ready,
    input logic             out_ready,
    input logic [DEPTH-1:0] marks,
    input logic [W-1:0]     out_word
);

    // R3
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (mclr)
        push |=> !in_ready);

    // R5
    unload_drops_ready_chk: assert property (@(posedge clk) disable iff (mclr)
        pop |=> !out_ready);

    // R5
    tail_held_chk: assert property (@(posedge clk) disable iff (mclr)
        (out_ready && !so_fall) |=> (out_ready && $stable(out_word)));

    // R1
    word_count_chk: assert property (@(posedge clk) disable iff (mclr)
        1'b1 |=> ($countones(marks) ==
                  $past($countones(marks)) + int'($past(push)) - int'($past(pop))));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (mclr)
        (si_rise && !in_ready) |=> ($countones(marks) <= $past($countones(marks))));

    // R6
    empty_unload_chk: assert property (@(posedge clk) disable iff (mclr)
        (so_fall && !out_ready && !push) |=> ($countones(marks) == $past($countones(marks))));

    // R7
    clear_flags_chk: assert property (@(posedge clk) disable iff (mclr)
        $past(mclr) |-> (in_ready && !out_ready));

endmodule

bind ripple_fifo ripple_fifo_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
    .clk       (clk),
    .mclr      (mclr),
    .si_rise   (si_rise),
    .so_fall   (so_fall),
    .push      (push),
    .pop       (pop),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .marks     (marks),
    .out_word  (out_word)
);

// File: tb/ripple_fifo_test.sv
`timescale 1ns/1ps
module ripple_fifo_test;

    localparam int DEPTH = 16;
    localparam int W     = 4;
    localparam logic [W-1:0] FILL_SEQ [DEPTH] = '{
        4'h3, 4'hA, 4'h5, 4'hC, 4'h0, 4'hF, 4'h1, 4'hE,
        4'h7, 4'h8, 4'h2, 4'hD, 4'h4, 4'hB, 4'h6, 4'h9
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         mclr;
    logic         shift_in;
    logic         shift_out;
    logic         float_out;
    logic [W-1:0] din;
    wire          in_ready;
    wire          out_ready;
    wire          q_drive;
    wire  [W-1:0] q_data;

    int checks = 0;
    int fails  = 0;

    ripple_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .mclr(mclr), .shift_in(shift_in), .din(din),
        .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
        .float_out(float_out), .q_drive(q_drive), .q_data(q_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [W-1:0] w);
        din = w; shift_in = 1'b1; step(1);
        shift_in = 1'b0; step(1);
    endtask

    task automatic pop();
        shift_out = 1'b0; step(1);
        shift_out = 1'b1; step(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        mclr = 1'b1; shift_in = 1'b0; shift_out = 1'b1; float_out = 1'b0; din = '0;
        step(2);
        mclr = 1'b0;
        step(1);

        // Reset state
        check("R7 in_ready after clear", in_ready, 1);
        check("R7 out_ready after clear", out_ready, 0);
        check("R9 driven by default", q_drive, 1);

        // Single word fall-through
        din = 4'hA; shift_in = 1'b1; step(1);
        check("R3 in_ready dips after accept", in_ready, 0);
        shift_in = 1'b0; step(1);
        check("R3 in_ready back after move", in_ready, 1);
        step(DEPTH-3);
        check("R2 not yet at tail", out_ready, 0);
        step(1);
        check("R2 reached tail", out_ready, 1);
        check("R2 tail word", q_data, 4'hA);

        // Unload single word, then unload on empty
        shift_out = 1'b0; step(1);
        check("R5 out_ready drops on unload", out_ready, 0);
        shift_out = 1'b1; step(1);
        check("R6 stays empty", out_ready, 0);
        pop();
        check("R6 unload on empty ignored", out_ready, 0);
        check("R6 head still free", in_ready, 1);

        // Fill from the vector table
        for (int i = 0; i < DEPTH; i++) begin
            int guard = 0;
            while (!in_ready && guard < 64) begin step(1); guard++; end
            push(FILL_SEQ[i]);
        end
        step(DEPTH+4);
        check("R4 full blocks input", in_ready, 0);
        check("R1 output ready when full", out_ready, 1);
        check("R1 oldest at tail", q_data, FILL_SEQ[0]);

        // Drain; first unload coincides with a refused load (R10, R4)
        for (int i = 0; i < DEPTH; i++) begin
            shift_out = 1'b0;
            if (i == 0) begin din = 4'hF; shift_in = 1'b1; end
            step(1);
            check("R5 ready low after unload", out_ready, 0);
            shift_out = 1'b1; shift_in = 1'b0;
            step(1);
            if (i < DEPTH-1) begin
                check("R5 next word ready", out_ready, 1);
                check("R1 order", q_data, FILL_SEQ[i+1]);
            end
        end
        step(DEPTH+4);
        check("R4 refused word not stored", out_ready, 0);
        check("R4 empty after drain", in_ready, 1);

        // Simultaneous load and unload on a partly filled FIFO
        push(4'h5);
        step(DEPTH);
        check("R10 setup word at tail", out_ready, 1);
        din = 4'h9; shift_in = 1'b1; shift_out = 1'b0; step(1);
        check("R10 unload took effect", out_ready, 0);
        check("R10 load took effect", in_ready, 0);
        shift_in = 1'b0; shift_out = 1'b1; step(1);
        step(DEPTH-3);
        check("R10 new word not yet at tail", out_ready, 0);
        step(1);
        check("R10 new word at tail", out_ready, 1);
        check("R10 new word value", q_data, 4'h9);
        pop();

        // Float does not disturb unload
        push(4'h1); push(4'h2);
        step(DEPTH+2);
        check("R9 setup word", q_data, 4'h1);
        float_out = 1'b1; #1;
        check("R9 parked drive", q_drive, 0);
        check("R9 parked data", q_data, 0);
        pop();
        float_out = 1'b0; #1;
        check("R9 unload while parked", out_ready, 1);
        check("R9 next word after parked unload", q_data, 4'h2);
        step(1);
        pop();
        step(DEPTH);
        check("R6 empty again", out_ready, 0);

        // Master clear keeps word bits
        push(4'hC);
        step(DEPTH+2);
        check("R7 setup word at tail", out_ready, 1);
        mclr = 1'b1; step(1);
        mclr = 1'b0;
        check("R7 clear drops out_ready", out_ready, 0);
        check("R7 clear raises in_ready", in_ready, 1);
        check("R7 word bits retained", q_data, 4'hC);

        // Load pending across clear
        din = 4'h6; shift_in = 1'b1; mclr = 1'b1; step(1);
        mclr = 1'b0; step(1);
        check("R8 loaded on release", in_ready, 0);
        shift_in = 1'b0; step(1);
        step(DEPTH-3);
        check("R8 not yet at tail", out_ready, 0);
        step(1);
        check("R8 word at tail", q_data, 4'h6);
        pop();

        // Held strobe takes one word only
        step(DEPTH);
        din = 4'h7; shift_in = 1'b1;
        step(DEPTH+4);
        shift_in = 1'b0; step(2);
        check("R3 held strobe word arrives", q_data, 4'h7);
        pop();
        step(DEPTH+2);
        check("R3 only one word taken", out_ready, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule